// File: doc/BRIEF.md
# First-Stage Gain Trim Loop

This block runs the digital half of a background loop that trims the interstage gain of the two leading 1.5-bit stages of a pipelined converter. A 31-bit linear feedback shift register supplies a pseudo-random sign for every converted sample. That sign chooses the polarity of the small calibration step that the analog side injects into the stage input.

The digital path receives three things for each sample: the back-end output, a slowly refreshed digital measurement of the injected amplitude, and a flag. The flag says whether the residue lies in a band where the back-end gain error cancels on average. The loop delays the sign so that it lines up with the pipeline latency. It then removes the sign-weighted amplitude from the back-end word and multiplies the remainder by the same sign. The result goes into a saturating accumulator for the stage being calibrated. The upper bits of each accumulator form the code for that stage's reference-adjust DAC.

The stages are calibrated one after the other. A select input picks the stage whose loop state may move. The other stage keeps its trim.

Top module: `cal_gain_loop`

## Requirements
- R1: The sign source is a 31-bit shift register that is loaded with the nonzero parameter SEED on reset. On each valid sample it shifts toward its top bit, and bit 0 takes bit 30 XOR bit 27. Its state is never all-zero.
- R2: `inj_sign_o` is a register. It takes bit 30 of the shift register as it stands before the advance at each valid sample, and it holds between valid samples. The encoding is 1 for −1 and 0 for +1. It is 0 after reset.
- R3: The sign applied to a valid sample is the value `inj_sign_o` held at the valid sample LAT valid samples earlier. For the first LAT valid samples after reset, the applied sign is +1.
- R4: With applied sign s, the error is `be_code_i − s·ref_meas_i`. Both inputs are two's complement. The correction `s·error` is added to the accumulator of the selected stage. One accumulator LSB is 2^−(ACC_W−CODE_W) of a DAC code step, which is 2^−21 by default.
- R5: An accumulator changes only on a valid sample with `in_region_i` high. Any other sample leaves both codes unchanged.
- R6: The code of each stage is the top CODE_W bits of its accumulator. The code register is refreshed only when `smp_valid_i` is high. Stage k occupies bits [k·CODE_W +: CODE_W] of `dac_code_o`.
- R7: `cal_sel_i` gives the stage index whose accumulator may update. The other stage's code does not change.
- R8: The accumulator saturates at 0 and at 2^ACC_W−1 and never wraps.
- R9: Reset loads every accumulator with 2^(ACC_W−1), so each code starts at 2^(CODE_W−1). It also clears the sign delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | A converted sample is present this cycle |
| in_region_i | input | 1 | Residue lies in a band where updates are allowed |
| cal_sel_i | input | SEL_W | Index of the stage being calibrated |
| be_code_i | input | DATA_W | Back-end output, two's complement |
| ref_meas_i | input | REF_W | Digitized amplitude of the injected step, two's complement |
| inj_sign_o | output | 1 | Sign for the analog injection (1 = −1) |
| dac_code_o | output | STAGES·CODE_W | Reference-adjust DAC codes, stage 0 in the low bits |

## Verification
Several properties are checked by assertions on every cycle: the shift register never reaches the all-zero state, and the injected sign and the codes do not move without a valid sample. The assertions also check that gated samples and samples for the unselected stage leave codes alone, that at most one accumulator is enabled, and that a code at either rail never jumps to the other rail. Other behaviour can only be shown by the bench's scenarios, which track an arithmetic model of every sample. These include the exact shift register sequence, the alignment of the delayed sign, the signed error and correlation arithmetic, and the clamp values. The bench sweeps back-end and amplitude values across their range for both stages, drives the accumulator into both rails, and mixes gated and idle samples.

// File: rtl/cal_gain_pkg.sv
package cal_gain_pkg;

  localparam int LFSR_W = 31;

  // one advance of the sign generator: x^31 + x^28 + 1
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] st);
    return {st[LFSR_W-2:0], st[30] ^ st[27]};
  endfunction

  // signed correlation term: s * (be - s*amp), neg=1 means s = -1
  function automatic int signed corr_term(input int signed be, input int signed amp,
                                          input logic neg);
    int signed err;
    err = neg ? (be + amp) : (be - amp);
    return neg ? -err : err;
  endfunction

endpackage

// File: rtl/cal_sign_gen.sv
module cal_sign_gen
  import cal_gain_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 31'h1,
  parameter int LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic              inj_sign_o,
  output logic              used_sign_o,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              sign_q;
  logic [LAT-1:0]    dly_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lfsr_q <= SEED;
      sign_q <= 1'b0;
    end else if (adv_i) begin
      sign_q <= lfsr_q[LFSR_W-1];
      lfsr_q <= lfsr_advance(lfsr_q);
    end
  end

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (!rst_ni)    dly_q <= '0;
        else if (adv_i) dly_q <= sign_q;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (!rst_ni)    dly_q <= '0;
        else if (adv_i) dly_q <= {dly_q[LAT-2:0], sign_q};
      end
    end
  endgenerate

  assign inj_sign_o  = sign_q;
  assign used_sign_o = dly_q[LAT-1];
  assign state_o     = lfsr_q;
endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
  parameter int ACC_W  = 28,
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              upd_i,
  input  logic signed [31:0] corr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sat_o
);
  localparam int EW = 33;
  localparam logic [ACC_W-1:0] MID = ACC_W'(1) << (ACC_W - 1);
  localparam logic signed [EW-1:0] TOP = $signed({{(EW-ACC_W){1'b0}}, {ACC_W{1'b1}}});

  logic [ACC_W-1:0]     acc_q, acc_d;
  logic [CODE_W-1:0]    code_q;
  logic signed [EW-1:0] sum;

  always_comb begin
    sum   = $signed({{(EW-ACC_W){1'b0}}, acc_q}) + $signed({corr_i[31], corr_i});
    sat_o = 1'b0;
    acc_d = acc_q;
    if (upd_i) begin
      if (sum < 0) begin
        acc_d = '0;
        sat_o = 1'b1;
      end else if (sum > TOP) begin
        acc_d = '1;
        sat_o = 1'b1;
      end else begin
        acc_d = sum[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q  <= MID;
      code_q <= MID[ACC_W-1 -: CODE_W];
    end else begin
      acc_q <= acc_d;
      if (valid_i) code_q <= acc_d[ACC_W-1 -: CODE_W];
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/cal_gain_loop.sv
module cal_gain_loop
  import cal_gain_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int DATA_W = 12,
  parameter int REF_W  = 12,
  parameter int ACC_W  = 28,
  parameter int CODE_W = 7,
  parameter int LAT    = 2,
  parameter logic [LFSR_W-1:0] SEED = 31'h1,
  localparam int SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic                     in_region_i,
  input  logic [SEL_W-1:0]         cal_sel_i,
  input  logic signed [DATA_W-1:0] be_code_i,
  input  logic signed [REF_W-1:0]  ref_meas_i,
  output logic                     inj_sign_o,
  output logic [STAGES*CODE_W-1:0] dac_code_o
);
  logic              used_sign;
  logic [LFSR_W-1:0] lfsr_state;
  logic signed [31:0] corr;
  logic              gate_open;
  logic [STAGES-1:0] upd_vec;
  logic [STAGES-1:0] sat_vec;

  cal_sign_gen #(.SEED(SEED), .LAT(LAT)) u_sign (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (smp_valid_i),
    .inj_sign_o (inj_sign_o),
    .used_sign_o(used_sign),
    .state_o    (lfsr_state)
  );

  assign corr      = corr_term(int'(be_code_i), int'(ref_meas_i), used_sign);
  assign gate_open = smp_valid_i & in_region_i;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      assign upd_vec[s] = gate_open & (cal_sel_i == SEL_W'(s));
      cal_accum #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_acc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(smp_valid_i),
        .upd_i  (upd_vec[s]),
        .corr_i (corr),
        .code_o (dac_code_o[s*CODE_W +: CODE_W]),
        .sat_o  (sat_vec[s])
      );
    end
  endgenerate
endmodule

// File: rtl/cal_gain_loop_chk.sv
module cal_gain_loop_chk
  import cal_gain_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int CODE_W = 7,
  parameter int SEL_W  = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     valid,
  input logic                     in_region,
  input logic [SEL_W-1:0]         sel,
  input logic                     inj_sign,
  input logic [STAGES*CODE_W-1:0] dac_code,
  input logic [LFSR_W-1:0]        lfsr_state,
  input logic [STAGES-1:0]        upd_vec
);
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0); // R1
  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(inj_sign)); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(dac_code)); // R6
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !in_region) |=> $stable(dac_code)); // R5
  AST_UPD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_vec) |-> (valid && in_region)); // R5
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_vec)); // R7

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_st
      AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_W'(s)) |=> $stable(dac_code[s*CODE_W +: CODE_W])); // R7
      AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code[s*CODE_W +: CODE_W] == {CODE_W{1'b1}})
          |=> (dac_code[s*CODE_W +: CODE_W] != '0)); // R8
      AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code[s*CODE_W +: CODE_W] == '0)
          |=> (dac_code[s*CODE_W +: CODE_W] != {CODE_W{1'b1}})); // R8
    end
  endgenerate
endmodule

bind cal_gain_loop cal_gain_loop_chk #(.STAGES(STAGES), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .valid     (smp_valid_i),
  .in_region (in_region_i),
  .sel       (cal_sel_i),
  .inj_sign  (inj_sign_o),
  .dac_code  (dac_code_o),
  .lfsr_state(lfsr_state),
  .upd_vec   (upd_vec)
);

// File: tb/cal_gain_loop_bench.sv
module cal_gain_loop_bench;
  localparam int STAGES = 2;
  localparam int DW = 12;
  localparam int RW = 12;
  localparam int AW = 16;
  localparam int CW = 7;
  localparam int LAT = 3;
  localparam logic [30:0] SEED = 31'h5A5A1234;
  localparam int FRAC = AW - CW;
  localparam int AMAX = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic region = 1'b0;
  logic [0:0] sel = '0;
  logic signed [DW-1:0] be = '0;
  logic signed [RW-1:0] rf = '0;
  logic inj_sign;
  logic [STAGES*CW-1:0] codes;

  always #5 clk = ~clk;

  cal_gain_loop #(.STAGES(STAGES), .DATA_W(DW), .REF_W(RW), .ACC_W(AW), .CODE_W(CW),
                  .LAT(LAT), .SEED(SEED)) u_cal_gain_loop (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .in_region_i(region),
    .cal_sel_i(sel), .be_code_i(be), .ref_meas_i(rf),
    .inj_sign_o(inj_sign), .dac_code_o(codes));

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // bench-side model
  logic [30:0] m_lfsr;
  bit m_sign;
  int m_acc [STAGES];
  bit m_hist [4096];
  int m_k;

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic check_all(input string rq);
    chk({rq, " R2 sign"}, int'(inj_sign), int'(m_sign));
    for (int s = 0; s < STAGES; s++)
      chk({rq, " code"}, int'(codes[s*CW +: CW]), m_acc[s] >>> FRAC);
  endtask

  task automatic sample(input bit v, input bit rg, input int st, input int b,
                        input int r, input string rq);
    bit used;
    int sg, err, corr, nx;
    @(negedge clk);
    valid = v; region = rg; sel = 1'(st); be = DW'(b); rf = RW'(r);
    @(posedge clk);
    if (v) begin
      used = (m_k >= LAT) ? m_hist[(m_k - LAT) % 4096] : 1'b0;
      m_hist[m_k % 4096] = m_sign;
      m_k++;
      m_sign = m_lfsr[30];
      m_lfsr = {m_lfsr[29:0], m_lfsr[30] ^ m_lfsr[27]};
      if (rg) begin
        sg = used ? -1 : 1;
        err = b - sg * r;
        corr = sg * err;
        nx = m_acc[st] + corr;
        if (nx < 0) nx = 0;
        if (nx > AMAX) nx = AMAX;
        m_acc[st] = nx;
      end
    end
    #1;
    check_all(rq);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int refs [8] = '{-2048, -1000, -1, 0, 1, 500, 1500, 2047};
    m_lfsr = SEED; m_sign = 0; m_k = 0;
    for (int s = 0; s < STAGES; s++) m_acc[s] = 1 << (AW - 1);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9: codes at mid-scale, sign cleared
    for (int s = 0; s < STAGES; s++)
      chk("R9 reset code", int'(codes[s*CW +: CW]), 1 << (CW - 1));
    chk("R9 reset sign", int'(inj_sign), 0);

    // R1 R3 R4: sweep stage 0 over back-end and amplitude values
    for (int ri = 0; ri < 8; ri++)
      for (int b = -2048; b < 2048; b += 67)
        sample(1, 1, 0, b, refs[ri], "R1 R3 R4 stage0");

    // R8: drive to upper rail then lower rail (be=0 gives corr = -s*s*ref = -ref)
    for (int i = 0; i < 40; i++) sample(1, 1, 0, 0, -2048, "R8 upper rail");
    chk("R8 top code", int'(codes[CW-1:0]), (1 << CW) - 1);
    for (int i = 0; i < 60; i++) sample(1, 1, 0, 0, 2047, "R8 lower rail");
    chk("R8 bottom code", int'(codes[CW-1:0]), 0);
    for (int i = 0; i < 20; i++) sample(1, 1, 0, 0, -1500, "R8 leave rail");

    // R5: gated samples leave codes unchanged
    for (int i = 0; i < 50; i++) sample(1, 0, i % 2, 2047 - 80 * i, -2048 + 77 * i, "R5 gated");

    // R6: idle cycles with changing data
    for (int i = 0; i < 30; i++) sample(0, 1, i % 2, -2048 + 130 * i, 900 - 60 * i, "R6 idle");

    // R7: stage 1 sweep, stage 0 must hold
    for (int ri = 0; ri < 8; ri++)
      for (int b = -2048; b < 2048; b += 97)
        sample(1, 1, 1, b, refs[7 - ri], "R7 stage1");

    // R3 R6: interleaved valid/idle with gating and alternating stages
    for (int i = 0; i < 200; i++)
      sample(i % 3 != 0, i % 5 != 0, (i / 7) % 2, (i * 211) % 4096 - 2048,
             (i * 131) % 4096 - 2048, "R3 R6 mixed");

    summary();
  end
endmodule